// File: doc/BRIEF.md
# GPIO Group Interrupt Status Bank

This block holds the event bookkeeping for one group of up to 16 pads. Per-pad event requests, produced by detection logic elsewhere, land in an interrupt status register and a wake status register. Two mask registers, interrupt enable and wake enable, select which pending bits reach the block's two outputs. The interrupt line rises when any pad has both status and enable set. The wake line rises when any pad has wake status and wake enable set and is not routed to the system interrupt path.

Software reaches the four registers through a simple word port. Both status registers clear only when software writes ones to them. A per-pad host-ownership input keeps firmware-owned pads from raising interrupt status. A parameter gives the number of populated pads, so a partial last group never reports anything on its empty bit positions.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all four registers read zero and both irq_o and wake_o are low.
- R2: The registers sit at byte offsets 0x0 (interrupt status), 0x4 (interrupt enable), 0x8 (wake status) and 0xC (wake enable). Address bits [1:0] are ignored. Bit i of each register belongs to pad i. Bits 31:16 read zero. Read data is combinational from the address in the same cycle.
- R3: An event request on a populated pad whose host_own_i bit is 1 sets that pad's interrupt status bit at the next clock edge. A pad whose host_own_i bit is 0 never sets its interrupt status bit.
- R4: Writing a 1 to a status bit (interrupt or wake) clears it at the next edge. Writing a 0 leaves it unchanged. Writing 0xFFFF clears the whole group.
- R5: When an event request and a write-1-to-clear reach the same status bit in the same cycle, the bit stays set. Other bits cleared by the same write still clear.
- R6: irq_o is high exactly when some pad has both interrupt status and interrupt enable set. It follows register contents with no added delay.
- R7: The interrupt enable and wake enable registers take the written value at the next edge and read it back.
- R8: An event request on any populated pad sets its wake status bit at the next edge, whatever the pad's ownership.
- R9: wake_o is high exactly when some pad has wake status set, wake enable set and route_sys_i clear. route_sys_i acts combinationally.
- R10: Bits at or above NUM_PADS are never set in any register, read as zero, and never drive irq_o or wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_req_i | input | GROUP_W | Per-pad event request, one cycle per event |
| host_own_i | input | GROUP_W | Per-pad host ownership; 0 blocks interrupt status |
| route_sys_i | input | GROUP_W | Per-pad route-to-system-interrupt flag; 1 blocks wake |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Combined wake |

## Verification
A status or enable change caused by an event request or a register write shows up one clock edge after the cycle in which it was driven. Read data, irq_o and wake_o then follow that register state in the same cycle, and a change on route_sys_i reaches wake_o with no edge at all. The bench drives every stimulus just after a rising edge and lets one edge pass where a register lies on the path. It queues each expected value and compares it at the following falling edge, when the result is settled. The collision case drives an event and a clearing write in one cycle, so that the rule that the event wins is resolved at a single edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NREG      = 4;
  localparam int unsigned IDX_W     = 2;
  localparam int unsigned WORD_LSB  = 2;

  typedef enum logic [IDX_W-1:0] {
    REG_STS  = 2'd0,
    REG_EN   = 2'd1,
    REG_WSTS = 2'd2,
    REG_WEN  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/gpio_sts_w1c.sv
module gpio_sts_w1c #(
  parameter int unsigned              W     = 16,
  parameter logic [W-1:0]             VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= ((q_q & ~clr_i) | set_i) & VALID;
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & VALID) != '0) |=> ((q_o & $past(set_i & VALID)) == $past(set_i & VALID))); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R4

  AST_UNPOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~VALID) == '0); // R10
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int unsigned  W     = 16,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i & VALID;
  end

  assign q_o = q_q;

  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(d_i & VALID))); // R7

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R7
endmodule

// File: rtl/gpio_bank_regport.sv
module gpio_bank_regport
  import gpio_irq_pkg::*;
#(
  parameter int unsigned GW     = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [GW-1:0]         rd_vec_i [NREG],
  output logic [NREG-1:0]       wr_o,
  output logic [DW-1:0]         rdata_o
);
  logic [IDX_W-1:0] idx;

  assign idx = addr_i[WORD_LSB +: IDX_W];

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    assign wr_o[g] = we_i && (idx == IDX_W'(g));
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[GW-1:0] = rd_vec_i[idx];
  end

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o)); // R2

  AST_WR_NEEDS_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o != '0) |-> we_i); // R2
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned GROUP_W  = 16,
  parameter int unsigned NUM_PADS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GROUP_W-1:0] evt_req_i,
  input  logic [GROUP_W-1:0] host_own_i,
  input  logic [GROUP_W-1:0] route_sys_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               wake_o
);
  localparam logic [GROUP_W-1:0] VALID_MASK = {GROUP_W{1'b1}} >> (GROUP_W - NUM_PADS);
  localparam int unsigned        NSTS       = 2;

  logic [GROUP_W-1:0] wdata_g;
  logic [NREG-1:0]    wr;
  logic [GROUP_W-1:0] rd_vec [NREG];
  logic [GROUP_W-1:0] sts_set [NSTS];
  logic [GROUP_W-1:0] sts_clr [NSTS];
  logic [GROUP_W-1:0] sts_q   [NSTS];
  logic [GROUP_W-1:0] en_q, wen_q;

  assign wdata_g = reg_wdata_i[GROUP_W-1:0];

  // index 0: interrupt status, index 1: wake status
  assign sts_set[0] = evt_req_i & host_own_i & VALID_MASK;
  assign sts_set[1] = evt_req_i & VALID_MASK;
  assign sts_clr[0] = wr[REG_STS]  ? wdata_g : '0;
  assign sts_clr[1] = wr[REG_WSTS] ? wdata_g : '0;

  for (genvar s = 0; s < NSTS; s++) begin : g_sts
    gpio_sts_w1c #(.W(GROUP_W), .VALID(VALID_MASK)) i_sts (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (sts_set[s]),
      .clr_i  (sts_clr[s]),
      .q_o    (sts_q[s])
    );
  end

  gpio_mask_reg #(.W(GROUP_W), .VALID(VALID_MASK)) i_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr[REG_EN]),
    .d_i    (wdata_g),
    .q_o    (en_q)
  );

  gpio_mask_reg #(.W(GROUP_W), .VALID(VALID_MASK)) i_wen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr[REG_WEN]),
    .d_i    (wdata_g),
    .q_o    (wen_q)
  );

  assign rd_vec[REG_STS]  = sts_q[0];
  assign rd_vec[REG_EN]   = en_q;
  assign rd_vec[REG_WSTS] = sts_q[1];
  assign rd_vec[REG_WEN]  = wen_q;

  gpio_bank_regport #(.GW(GROUP_W), .DW(DATA_W), .AW(ADDR_W)) i_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .rd_vec_i (rd_vec),
    .wr_o     (wr),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o  = |(sts_q[0] & en_q);
  assign wake_o = |(sts_q[1] & wen_q & ~route_sys_i);

  AST_OWN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q[0] & ~$past(sts_q[0]) & ~$past(host_own_i)) == '0)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0)); // R6

  AST_WAKE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ((wen_q & ~route_sys_i) != '0)); // R9

  AST_WAKE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_req_i & VALID_MASK) != '0) |=> ((sts_q[1] & $past(evt_req_i & VALID_MASK)) == $past(evt_req_i & VALID_MASK))); // R8

  AST_RDATA_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:GROUP_W] == '0); // R2
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int unsigned GW = 16;
  localparam int unsigned NP = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [GW-1:0] evt_req_i = '0;
  logic [GW-1:0] host_own_i = '0;
  logic [GW-1:0] route_sys_i = '0;
  logic          reg_we_i = 1'b0;
  logic [3:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          irq_o, wake_o;

  gpio_irq_bank #(.GROUP_W(GW), .NUM_PADS(NP)) i_gpio_irq_bank (
    .clk_i, .rst_ni, .evt_req_i, .host_own_i, .route_sys_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o, .wake_o
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 wake
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q [$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // monitor: compare one queued item at each falling edge
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = reg_rdata_o;
        1:       act = {31'd0, irq_o};
        default: act = {31'd0, wake_o};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr_i = a;
    #1;
    push(0, exp, tag);
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    push(1, {31'd0, exp}, tag);
  endtask

  task automatic chk_wake(input bit exp, input string tag);
    push(2, {31'd0, exp}, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk_i); #2;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #2;
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic pulse(input logic [GW-1:0] m);
    @(posedge clk_i); #2;
    evt_req_i = m;
    @(posedge clk_i); #2;
    evt_req_i = '0;
  endtask

  task automatic wr_evt(input logic [3:0] a, input logic [31:0] d, input logic [GW-1:0] m);
    @(posedge clk_i); #2;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; evt_req_i = m;
    @(posedge clk_i); #2;
    reg_we_i = 1'b0; reg_wdata_i = '0; evt_req_i = '0;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #2;

    // R1 reset state
    chk_reg(4'h0, 32'h0, "R1 status reset");
    chk_reg(4'h4, 32'h0, "R1 enable reset");
    chk_reg(4'h8, 32'h0, "R1 wake status reset");
    chk_reg(4'hC, 32'h0, "R1 wake enable reset");
    chk_irq(1'b0, "R1 irq reset");
    chk_wake(1'b0, "R1 wake reset");

    // R3 ownership gating, R8 wake sets regardless
    host_own_i = 16'h0F0F;
    pulse(16'h00FF);
    chk_reg(4'h0, 32'h0000_000F, "R3 only owned pads set");
    chk_reg(4'h8, 32'h0000_00FF, "R8 wake status all populated pads");
    chk_irq(1'b0, "R6 no enable no irq");

    // R6 enable masking, R7 writeback
    wr(4'h4, 32'h0000_0002);
    chk_reg(4'h4, 32'h0000_0002, "R7 enable readback");
    chk_irq(1'b1, "R6 enabled pending");
    wr(4'h4, 32'h0000_0010);
    chk_irq(1'b0, "R6 enable on idle pad");
    wr(4'h4, 32'hFFFF_FFFF);
    chk_reg(4'h4, 32'h0000_0FFF, "R10 enable limited to populated");
    chk_reg(4'h5, 32'h0000_0FFF, "R2 low address bits ignored");

    // R4 write-1-to-clear
    wr(4'h0, 32'h0000_0003);
    chk_reg(4'h0, 32'h0000_000C, "R4 w1c clears ones");
    wr(4'h0, 32'h0);
    chk_reg(4'h0, 32'h0000_000C, "R4 zero write no effect");

    // R10 unpopulated pads
    host_own_i = 16'hFFFF;
    pulse(16'hF000);
    chk_reg(4'h0, 32'h0000_000C, "R10 status unpopulated ignored");
    chk_reg(4'h8, 32'h0000_00FF, "R10 wake unpopulated ignored");
    wr(4'h0, 32'h0000_FFFF);
    chk_reg(4'h0, 32'h0, "R4 clear whole group");
    chk_irq(1'b0, "R6 cleared no irq");

    // R5 collision
    pulse(16'h0060);
    chk_reg(4'h0, 32'h0000_0060, "R3 owned pads set");
    wr_evt(4'h0, 32'h0000_0060, 16'h0020);
    chk_reg(4'h0, 32'h0000_0020, "R5 event beats clear");
    chk_irq(1'b1, "R6 pending after collision");

    // R8 / R9 wake path
    wr(4'h8, 32'h0000_FFFF);
    chk_reg(4'h8, 32'h0, "R4 wake status cleared");
    host_own_i = 16'h0000;
    pulse(16'h0100);
    chk_reg(4'h8, 32'h0000_0100, "R8 wake set on unowned pad");
    chk_reg(4'h0, 32'h0000_0020, "R3 unowned pad no status");
    chk_wake(1'b0, "R9 wake disabled");
    wr(4'hC, 32'h0000_0100);
    chk_reg(4'hC, 32'h0000_0100, "R7 wake enable readback");
    chk_wake(1'b1, "R9 wake enabled");
    route_sys_i = 16'h0100;
    #1;
    chk_wake(1'b0, "R9 routed pad blocks wake");
    route_sys_i = 16'h0000;
    #1;
    chk_wake(1'b1, "R9 route cleared");
    wr(4'h8, 32'h0000_0100);
    chk_wake(1'b0, "R9 wake cleared");
    chk_reg(4'h8, 32'h0, "R4 wake w1c");

    @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule